// File: doc/BRIEF.md
# Serial EEPROM Word Reader

This block fetches a single 16-bit word from a small three-wire serial EEPROM of the 93C46 class. A host issues a one-cycle start strobe together with a 6-bit word address. The block raises `busy` and walks the pin-level sequence on chip select, serial clock and data-in. It then returns the word on `dataOut` with a one-cycle `doneP` pulse.

On the serial side, chip select goes high while the clock is still low. A leading 1 is sent as a start bit. Next comes an 8-bit command made of the read opcode 0x80 ORed with the zero-extended address, sent MSB first. After that, sixteen data bits are clocked in from the EEPROM, MSB first. Every high and low half of the serial clock lasts `HALF_CYC` system clocks, which keeps the serial clock far below the EEPROM's rated speed. Write, erase and write-enable commands are not produced, and the word that comes back is not interpreted.

Top module: `mwRomReader`

## Requirements
- R1: While reset is asserted and after it, `romCs`, `romSk`, `romDi`, `busy`, `doneP` and `dataOut` are all 0.
- R2: A start strobe seen while idle sets `busy` on the next cycle. `romCs` then rises while `romSk` and `romDi` are both 0, and `romSk` only rises while `romCs` is high.
- R3: On the first rising `romSk` of a read, `romDi` is 1 (start bit).
- R4: The next 8 rising `romSk` edges carry 0x80 | address on `romDi`, MSB first. `romDi` changes only while `romSk` is low.
- R5: The following 16 rising `romSk` edges read `romDo`, MSB first. Each bit is sampled after the clock went high, at the edge where `romSk` returns low. The assembled word, with the first bit read landing in bit 15, appears on `dataOut`.
- R6: With chip select high, every `romSk` high phase and every low phase between two rises lasts exactly `HALF_CYC` clocks. The low time from `romCs` rising to the first rise is 2·`HALF_CYC`.
- R7: A read has exactly 25 rising `romSk` edges. After it, `romCs` and `romSk` fall together and stay low.
- R8: `doneP` is high for exactly one cycle per read. `busy` is 0 in that cycle, and `dataOut` takes the new word in that cycle. A start strobe in the `doneP` cycle begins a new read.
- R9: Start strobes that arrive while `busy` is high are ignored. They change neither the read in progress nor the number of reads performed.
- R10: `dataOut` changes only in a `doneP` cycle. It holds the previous word throughout a later read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | One-cycle request to read a word |
| wordAddr | input | 6 | Word address, sampled with `startReq` |
| busy | output | 1 | High while a read is in progress |
| doneP | output | 1 | One-cycle pulse when `dataOut` is updated |
| dataOut | output | 16 | Last word read |
| romCs | output | 1 | EEPROM chip select |
| romSk | output | 1 | EEPROM serial clock |
| romDi | output | 1 | Serial data toward the EEPROM |
| romDo | input | 1 | Serial data from the EEPROM |

## Verification
A behavioural EEPROM in the bench decodes the command from the pins and answers with an address-dependent word. A design that sends a wrong or shifted command, drops the start bit, or samples one half-phase early therefore returns the wrong word. Phase lengths are timed at the pins, so a counter that is off by one in the high or low half shows up directly. A stray start strobe in the middle of a read is used to catch a sequencer that restarts or issues a second done pulse. The output word is watched across a later read to catch a register that leaks partial shift data.

// File: rtl/mwrd_pkg.sv
package mwrd_pkg;
  typedef enum logic [1:0] {DI_ZERO, DI_ONE, DI_CMD} diSel_e;

  typedef struct packed {
    logic   loadCmd;
    logic   shiftCmd;
    logic   sampleReq;
    logic   finish;
    logic   pinCs;
    logic   pinSk;
    diSel_e diSel;
  } dpStrobe_t;
endpackage

// File: rtl/mwrd_ctrl.sv
module mwrd_ctrl
  import mwrd_pkg::*;
#(
  parameter int HALF_CYC = 4,
  parameter int CMD_W    = 8,
  parameter int DATA_W   = 16
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      startReq,
  output logic      busy,
  output dpStrobe_t ctl
);
  localparam int CNT_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam int MAX_B = (CMD_W > DATA_W) ? CMD_W : DATA_W;
  localparam int BIT_W = (MAX_B > 1) ? $clog2(MAX_B) : 1;

  typedef enum logic [3:0] {
    S_IDLE, S_CSUP, S_STLO, S_STHI, S_CLO, S_CHI, S_DLO, S_DHI, S_END, S_DONE
  } state_e;

  state_e             state;
  logic [CNT_W-1:0]   phaseCnt;
  logic [BIT_W-1:0]   bitIdx;
  logic               phaseLast;

  assign phaseLast = (phaseCnt == CNT_W'(HALF_CYC - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      phaseCnt <= '0;
      bitIdx   <= '0;
    end else if (state == S_IDLE) begin
      phaseCnt <= '0;
      bitIdx   <= '0;
      if (startReq) state <= S_CSUP;
    end else if (state == S_DONE) begin
      state <= S_IDLE;
    end else if (!phaseLast) begin
      phaseCnt <= phaseCnt + 1'b1;
    end else begin
      phaseCnt <= '0;
      case (state)
        S_CSUP: state <= S_STLO;
        S_STLO: state <= S_STHI;
        S_STHI: begin state <= S_CLO; bitIdx <= '0; end
        S_CLO:  state <= S_CHI;
        S_CHI: begin
          if (bitIdx == BIT_W'(CMD_W - 1)) begin
            state  <= S_DLO;
            bitIdx <= '0;
          end else begin
            state  <= S_CLO;
            bitIdx <= bitIdx + 1'b1;
          end
        end
        S_DLO:  state <= S_DHI;
        S_DHI: begin
          if (bitIdx == BIT_W'(DATA_W - 1)) begin
            state <= S_END;
          end else begin
            state  <= S_DLO;
            bitIdx <= bitIdx + 1'b1;
          end
        end
        S_END:   state <= S_DONE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl           = '0;
    ctl.loadCmd   = (state == S_IDLE) && startReq;
    ctl.shiftCmd  = (state == S_CHI) && phaseLast;
    ctl.sampleReq = (state == S_DHI) && phaseLast;
    ctl.finish    = (state == S_DONE);
    ctl.pinCs     = !(state inside {S_IDLE, S_END, S_DONE});
    ctl.pinSk     = (state inside {S_STHI, S_CHI, S_DHI});
    case (state)
      S_STLO, S_STHI: ctl.diSel = DI_ONE;
      S_CLO,  S_CHI:  ctl.diSel = DI_CMD;
      default:        ctl.diSel = DI_ZERO;
    endcase
  end

  assign busy = (state != S_IDLE);

  // busy only rises in answer to a start strobe
  assert_busy_from_start_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(startReq));

  // a strobe during a read never sends the sequencer back to chip-select setup
  assert_no_restart_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && state != S_CSUP) |=> state != S_CSUP);

  // the high half of the data clock always ends in exactly one sample request
  assert_sample_per_bit_R5: assert property (@(posedge clk) disable iff (!rstN)
    ctl.sampleReq |=> (state == S_DLO || state == S_END));
endmodule

// File: rtl/mwrd_datapath.sv
module mwrd_datapath
  import mwrd_pkg::*;
#(
  parameter int              ADDR_W  = 6,
  parameter int              CMD_W   = 8,
  parameter int              DATA_W  = 16,
  parameter logic [CMD_W-1:0] READ_OP = 8'h80
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         ctl,
  input  logic [ADDR_W-1:0] wordAddr,
  input  logic              romDo,
  output logic              romCs,
  output logic              romSk,
  output logic              romDi,
  output logic [DATA_W-1:0] dataOut,
  output logic              doneP
);
  logic [CMD_W-1:0]  cmdReg;
  logic [DATA_W-1:0] shiftIn;
  logic              sampleDly;
  logic              diNext;

  always_comb begin
    case (ctl.diSel)
      DI_ONE:  diNext = 1'b1;
      DI_CMD:  diNext = cmdReg[CMD_W-1];
      default: diNext = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdReg    <= '0;
      shiftIn   <= '0;
      sampleDly <= 1'b0;
      dataOut   <= '0;
      doneP     <= 1'b0;
      romCs     <= 1'b0;
      romSk     <= 1'b0;
      romDi     <= 1'b0;
    end else begin
      if (ctl.loadCmd)       cmdReg <= READ_OP | CMD_W'(wordAddr);
      else if (ctl.shiftCmd) cmdReg <= {cmdReg[CMD_W-2:0], 1'b0};
      sampleDly <= ctl.sampleReq;
      if (sampleDly) shiftIn <= {shiftIn[DATA_W-2:0], romDo};
      if (ctl.finish) dataOut <= shiftIn;
      doneP <= ctl.finish;
      romCs <= ctl.pinCs;
      romSk <= ctl.pinSk;
      romDi <= diNext;
    end
  end

  assert_sk_needs_cs_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(romSk) |-> romCs);

  assert_di_steady_high_R4: assert property (@(posedge clk) disable iff (!rstN)
    (romSk && $past(romSk)) |-> $stable(romDi));

  assert_cs_drop_clk_low_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(romCs) |-> !romSk);

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    doneP |=> !doneP);

  assert_data_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(dataOut) |-> doneP);
endmodule

// File: rtl/mwRomReader.sv
module mwRomReader
  import mwrd_pkg::*;
#(
  parameter int               HALF_CYC = 4,
  parameter int               ADDR_W   = 6,
  parameter int               CMD_W    = 8,
  parameter int               DATA_W   = 16,
  parameter logic [CMD_W-1:0] READ_OP  = 8'h80
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic [ADDR_W-1:0] wordAddr,
  output logic              busy,
  output logic              doneP,
  output logic [DATA_W-1:0] dataOut,
  output logic              romCs,
  output logic              romSk,
  output logic              romDi,
  input  logic              romDo
);
  dpStrobe_t ctl;

  mwrd_ctrl #(.HALF_CYC(HALF_CYC), .CMD_W(CMD_W), .DATA_W(DATA_W)) uCtrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .busy(busy), .ctl(ctl)
  );

  mwrd_datapath #(.ADDR_W(ADDR_W), .CMD_W(CMD_W), .DATA_W(DATA_W), .READ_OP(READ_OP)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wordAddr(wordAddr), .romDo(romDo),
    .romCs(romCs), .romSk(romSk), .romDi(romDi), .dataOut(dataOut), .doneP(doneP)
  );
endmodule

// File: tb/sim_mwRomReader.sv
module sim_mwRomReader;
  localparam int HC = 3;
  localparam int NV = 8;
  localparam logic [5:0] ADDRS [NV] = '{6'd0, 6'd63, 6'd21, 6'd42, 6'd1, 6'd32, 6'd5, 6'd58};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0;
  logic [5:0] wordAddr = '0;
  logic busy, doneP, romCs, romSk, romDi;
  logic romDo = 1'b0;
  logic [15:0] dataOut;

  int total = 0, bad = 0;
  int edgeCnt = 0, csUpBad = 0, skNoCsBad = 0, phaseBad = 0, doneCnt = 0;
  int runLen = 0;
  bit lowFirst = 1'b0, prevCs = 1'b0, prevSk = 1'b0, startSeen = 1'b0;
  logic [7:0] cmdSeen = '0;

  always #4 clk = ~clk;

  mwRomReader #(.HALF_CYC(HC)) u0 (
    .clk(clk), .rstN(rstN), .startReq(startReq), .wordAddr(wordAddr),
    .busy(busy), .doneP(doneP), .dataOut(dataOut),
    .romCs(romCs), .romSk(romSk), .romDi(romDi), .romDo(romDo)
  );

  function automatic logic [15:0] romWord(input logic [5:0] a);
    return {a, ~a, 4'b1010};
  endfunction

  // behavioural EEPROM
  always @(posedge romCs) begin
    edgeCnt = 0; cmdSeen = '0; startSeen = 1'b0;
    if (romSk || romDi) csUpBad++;
  end

  always @(posedge romSk) begin
    logic [15:0] w;
    if (!romCs) skNoCsBad++;
    edgeCnt++;
    if (edgeCnt == 1) startSeen = romDi;
    else if (edgeCnt <= 9) cmdSeen = {cmdSeen[6:0], romDi};
    if (edgeCnt >= 10 && edgeCnt <= 25) begin
      w = romWord(cmdSeen[5:0]);
      romDo = w[25 - edgeCnt];
    end
  end

  // phase timing monitor
  always @(negedge clk) begin
    if (romCs === 1'b1 && !prevCs) begin
      runLen = 1; lowFirst = 1'b1;
    end else if (romCs === 1'b1) begin
      if (romSk == prevSk) runLen++;
      else begin
        if (prevSk && runLen != HC) phaseBad++;
        if (!prevSk && runLen != (lowFirst ? 2*HC : HC)) phaseBad++;
        lowFirst = 1'b0; runLen = 1;
      end
    end else if (prevCs) begin
      if (!prevSk || runLen != HC) phaseBad++;
    end
    prevCs = (romCs === 1'b1);
    prevSk = (romSk === 1'b1);
    if (doneP === 1'b1) doneCnt++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic startRead(input logic [5:0] a);
    startReq = 1'b1; wordAddr = a;
    @(negedge clk);
    startReq = 1'b0;
    chk(busy === 1'b1, "R2 busy after start", busy, 1);
  endtask

  task automatic waitDone();
    int n = 0;
    while (doneP !== 1'b1 && n < 3000) begin @(negedge clk); n++; end
    chk(doneP === 1'b1, "R8 done pulse seen", doneP, 1);
    chk(busy === 1'b0, "R8 busy low with done", busy, 0);
  endtask

  task automatic checkRead(input logic [5:0] a);
    chk(dataOut == romWord(a), "R5 word read", dataOut, romWord(a));
    chk(startSeen == 1'b1, "R3 start bit", startSeen, 1);
    chk(cmdSeen == (8'h80 | {2'b00, a}), "R4 command", cmdSeen, 8'h80 | {2'b00, a});
    chk(edgeCnt == 25, "R7 clock count", edgeCnt, 25);
    chk(phaseBad == 0, "R6 phase length", phaseBad, 0);
    chk(csUpBad == 0 && skNoCsBad == 0, "R2 cs before clock", csUpBad + skNoCsBad, 0);
    @(negedge clk);
    chk(doneP === 1'b0, "R8 done one cycle", doneP, 0);
    chk(romCs === 1'b0 && romSk === 1'b0, "R7 pins low at end", {romCs, romSk}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=expired expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int dc;
    repeat (3) @(negedge clk);
    chk({romCs, romSk, romDi, busy, doneP} === 5'b0 && dataOut === 16'h0,
        "R1 reset state", {romCs, romSk, romDi, busy, doneP}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk({romCs, romSk, romDi, busy, doneP} === 5'b0 && dataOut === 16'h0,
        "R1 idle after reset", dataOut, 0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      startRead(ADDRS[i]);
      waitDone();
      checkRead(ADDRS[i]);
      repeat (2) @(negedge clk);
    end

    // R9: strobe during a read is ignored
    dc = doneCnt;
    startRead(6'd17);
    repeat (60) @(negedge clk);
    startReq = 1'b1; wordAddr = 6'd40;
    @(negedge clk);
    startReq = 1'b0;
    waitDone();
    checkRead(6'd17);
    repeat (300) @(negedge clk);
    chk(doneCnt - dc == 1, "R9 single read", doneCnt - dc, 1);
    chk(dataOut == romWord(6'd17) && romCs === 1'b0, "R9 no second read", dataOut, romWord(6'd17));

    // R10: hold across a later read
    repeat (40) @(negedge clk);
    chk(dataOut == romWord(6'd17), "R10 hold idle", dataOut, romWord(6'd17));
    startRead(6'd9);
    repeat (80) @(negedge clk);
    chk(dataOut == romWord(6'd17), "R10 hold mid read", dataOut, romWord(6'd17));
    waitDone();
    checkRead(6'd9);

    // R8: start in the done cycle
    startRead(6'd12);
    waitDone();
    startRead(6'd50);
    waitDone();
    checkRead(6'd50);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule